// File: doc/BRIEF.md
# Wavefront Lane Permutation Network

This block moves 32-bit words between the lanes of a 64-lane wavefront in a single registered stage. The wavefront is split into four rows of sixteen lanes, and each row is split into four banks of four lanes. For every destination lane, a 4-bit kind code and an 8-bit argument pick one source lane. The source can lie in the same quad, the same half-row, the same row or anywhere in the wavefront.

A per-row mask and a per-bank mask can stop any lane from taking the permuted word. A blocked lane keeps the word supplied on the old-value input. A lane whose source falls outside its group gets either zero or its old value, depending on a zero-fill flag. An illegal kind code, or an illegal row-shift amount, raises an error flag, and the whole vector then passes the old values through. The result appears one clock after the inputs are presented. The consuming datapath and any instruction decode sit outside this block.

Top module: `lperm_net`

## Requirements
- R1: Kind 0 is a crossbar inside each aligned group of four lanes. The lane at position p (0..3) of its quad takes the quad's lane number `arg[2p+1:2p]`.
- R2: Kind 1 gives row lane position q the word of position q+n in the same row, and kind 2 gives it the word of position q-n, where n = `arg` (legal range 1..15). A position that falls outside 0..15 is an invalid source.
- R3: Kind 3 rotates each row: position q takes position (q-n) mod 16 of the same row, where n = `arg` (legal range 1..15).
- R4: Kinds 4 to 7 move data across the whole wavefront by one lane. Kind 4 gives lane i the word of lane i+1, and lane 63 has an invalid source. Kind 5 gives lane i the word of lane i-1, and lane 0 has an invalid source. Kind 6 gives lane i the word of lane (i-1) mod 64. Kind 7 gives lane i the word of lane (i+1) mod 64.
- R5: Kind 8 reverses each row, so position q takes position 15-q. Kind 9 reverses each 8-lane half-row, so half position h takes half position 7-h.
- R6: Kind 10 gives every lane of rows 1 to 3 the word of the last lane of the row before it, and row 0 has an invalid source. Kind 11 gives every lane of rows 2 and 3 the word of lane 31, and rows 0 and 1 have an invalid source.
- R7: Lane i belongs to row i/16 and to bank (i mod 16)/4. If `row_mask` bit (row) or `bank_mask` bit (bank) is 0, the lane outputs its old value. This rule takes precedence over zero fill.
- R8: An enabled lane with an invalid source outputs zero when `zero_fill` is 1, and its old value when `zero_fill` is 0.
- R9: Kind codes 12 to 15 are illegal. Kinds 1 to 3 with `arg` equal to 0 or greater than 15 are also illegal. An illegal input sets `illegal` and makes every lane output its old value.
- R10: `res_vec` and `illegal` are registered and reflect the inputs sampled on the previous rising clock edge. A synchronous active-high reset clears both to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_vec | input | 2048 | Source words, lane i in bits [32i+31:32i] |
| old_vec | input | 2048 | Old words kept by masked or invalid lanes |
| kind | input | 4 | Permutation kind code |
| perm_arg | input | 8 | Quad selectors or row move amount |
| row_mask | input | 4 | Per-row enable, bit r for row r |
| bank_mask | input | 4 | Per-bank enable, bit b for bank b of each row |
| zero_fill | input | 1 | Invalid-source lanes output zero when 1 |
| res_vec | output | 2048 | Registered permuted lane vector |
| illegal | output | 1 | Registered error flag for a bad kind or amount |

## Verification
The bench builds the network with its default parameters: 64 lanes, 16-lane rows, 4-lane banks and 32-bit words. With these values the row edges at positions 0 and 15 are reachable, as are the wrap between lanes 63 and 0, the fixed broadcast source at lane 31, and every row-mask and bank-mask bit. Shift amounts of 1 and 15 probe the ends of the legal range. Amounts of 0 and 16, together with the two ends of the unused kind range, probe the error path.

// File: rtl/lperm_pkg.sv
package lperm_pkg;

  typedef enum logic [3:0] {
    LP_QUAD_XBAR    = 4'd0,
    LP_ROW_PULL_HI  = 4'd1,
    LP_ROW_PULL_LO  = 4'd2,
    LP_ROW_SPIN     = 4'd3,
    LP_WAVE_PULL_HI = 4'd4,
    LP_WAVE_PULL_LO = 4'd5,
    LP_WAVE_SPIN_R  = 4'd6,
    LP_WAVE_SPIN_L  = 4'd7,
    LP_ROW_REV      = 4'd8,
    LP_HALF_REV     = 4'd9,
    LP_BCAST_ROWEND = 4'd10,
    LP_BCAST_MID    = 4'd11
  } lp_kind_e;

  localparam int LP_KIND_COUNT = 12;

endpackage

// File: rtl/lperm_argchk.sv
module lperm_argchk #(
  parameter int ROW_LANES = 16,
  parameter int ARG_W     = 8
) (
  input  logic [3:0]       kind,
  input  logic [ARG_W-1:0] arg,
  output logic             bad
);
  import lperm_pkg::*;

  logic row_move;

  always_comb begin
    row_move = (kind == LP_ROW_PULL_HI) || (kind == LP_ROW_PULL_LO) ||
               (kind == LP_ROW_SPIN);
    bad = (int'(kind) >= LP_KIND_COUNT) ||
          (row_move && ((int'(arg) == 0) || (int'(arg) > ROW_LANES - 1)));
  end

endmodule

// File: rtl/lperm_route.sv
module lperm_route #(
  parameter int LANES      = 64,
  parameter int ROW_LANES  = 16,
  parameter int BANK_LANES = 4,
  parameter int ARG_W      = 8,
  parameter int LANE       = 0,
  localparam int IDX_W     = $clog2(LANES)
) (
  input  logic [3:0]       kind,
  input  logic [ARG_W-1:0] arg,
  output logic [IDX_W-1:0] src_idx,
  output logic             src_ok
);
  import lperm_pkg::*;

  localparam int SEL_W   = $clog2(BANK_LANES);
  localparam int ROW     = LANE / ROW_LANES;
  localparam int POS     = LANE % ROW_LANES;
  localparam int RBASE   = ROW * ROW_LANES;
  localparam int QPOS    = LANE % BANK_LANES;
  localparam int QBASE   = LANE - QPOS;
  localparam int HALF    = ROW_LANES / 2;
  localparam int HPOS    = POS % HALF;
  localparam int HBASE   = LANE - HPOS;
  localparam int MID_SRC = 2 * ROW_LANES - 1;

  lp_kind_e k;
  int amt;
  int t;
  int pick;

  always_comb begin
    k      = lp_kind_e'(kind);
    amt    = int'(arg);
    t      = 0;
    pick   = LANE;
    src_ok = 1'b0;
    case (k)
      LP_QUAD_XBAR: begin
        pick   = QBASE + int'(arg[QPOS*SEL_W +: SEL_W]);
        src_ok = 1'b1;
      end
      LP_ROW_PULL_HI: begin
        t = POS + amt;
        if (t < ROW_LANES) begin
          pick   = RBASE + t;
          src_ok = 1'b1;
        end
      end
      LP_ROW_PULL_LO: begin
        t = POS - amt;
        if (t >= 0) begin
          pick   = RBASE + t;
          src_ok = 1'b1;
        end
      end
      LP_ROW_SPIN: begin
        t      = (POS + ROW_LANES - (amt % ROW_LANES)) % ROW_LANES;
        pick   = RBASE + t;
        src_ok = 1'b1;
      end
      LP_WAVE_PULL_HI: begin
        if (LANE + 1 < LANES) begin
          pick   = LANE + 1;
          src_ok = 1'b1;
        end
      end
      LP_WAVE_PULL_LO: begin
        if (LANE > 0) begin
          pick   = LANE - 1;
          src_ok = 1'b1;
        end
      end
      LP_WAVE_SPIN_R: begin
        pick   = (LANE + LANES - 1) % LANES;
        src_ok = 1'b1;
      end
      LP_WAVE_SPIN_L: begin
        pick   = (LANE + 1) % LANES;
        src_ok = 1'b1;
      end
      LP_ROW_REV: begin
        pick   = RBASE + ROW_LANES - 1 - POS;
        src_ok = 1'b1;
      end
      LP_HALF_REV: begin
        pick   = HBASE + HALF - 1 - HPOS;
        src_ok = 1'b1;
      end
      LP_BCAST_ROWEND: begin
        if (ROW > 0) begin
          pick   = RBASE - 1;
          src_ok = 1'b1;
        end
      end
      LP_BCAST_MID: begin
        if (ROW >= 2) begin
          pick   = MID_SRC;
          src_ok = 1'b1;
        end
      end
      default: ;
    endcase
    src_idx = IDX_W'(pick);
  end

endmodule

// File: rtl/lperm_lane.sv
module lperm_lane #(
  parameter int DW       = 32,
  parameter int ROWS     = 4,
  parameter int BANKS    = 4,
  parameter int ROW_IDX  = 0,
  parameter int BANK_IDX = 0
) (
  input  logic [DW-1:0]    picked,
  input  logic [DW-1:0]    old_word,
  input  logic             src_ok,
  input  logic             hold,
  input  logic             zero_fill,
  input  logic [ROWS-1:0]  row_mask,
  input  logic [BANKS-1:0] bank_mask,
  output logic [DW-1:0]    out_word
);

  logic enabled;

  always_comb begin
    enabled = row_mask[ROW_IDX] && bank_mask[BANK_IDX] && !hold;
    if (!enabled)
      out_word = old_word;
    else if (!src_ok)
      out_word = zero_fill ? '0 : old_word;
    else
      out_word = picked;
  end

endmodule

// File: rtl/lperm_net.sv
module lperm_net #(
  parameter int LANES      = 64,
  parameter int ROW_LANES  = 16,
  parameter int BANK_LANES = 4,
  parameter int DW         = 32,
  parameter int ARG_W      = 8,
  localparam int ROWS      = LANES / ROW_LANES,
  localparam int BANKS     = ROW_LANES / BANK_LANES,
  localparam int VW        = LANES * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VW-1:0]    src_vec,
  input  logic [VW-1:0]    old_vec,
  input  logic [3:0]       kind,
  input  logic [ARG_W-1:0] perm_arg,
  input  logic [ROWS-1:0]  row_mask,
  input  logic [BANKS-1:0] bank_mask,
  input  logic             zero_fill,
  output logic [VW-1:0]    res_vec,
  output logic             illegal
);
  import lperm_pkg::*;

  localparam int IDX_W = $clog2(LANES);

  logic          bad;
  logic [VW-1:0] nxt_vec;
  logic          live;

  lperm_argchk #(
    .ROW_LANES(ROW_LANES),
    .ARG_W    (ARG_W)
  ) u_argchk (
    .kind(kind),
    .arg (perm_arg),
    .bad (bad)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IDX_W-1:0] idx;
    logic             ok;
    logic [DW-1:0]    picked;

    lperm_route #(
      .LANES     (LANES),
      .ROW_LANES (ROW_LANES),
      .BANK_LANES(BANK_LANES),
      .ARG_W     (ARG_W),
      .LANE      (g)
    ) u_route (
      .kind   (kind),
      .arg    (perm_arg),
      .src_idx(idx),
      .src_ok (ok)
    );

    assign picked = src_vec[int'(idx)*DW +: DW];

    lperm_lane #(
      .DW      (DW),
      .ROWS    (ROWS),
      .BANKS   (BANKS),
      .ROW_IDX (g / ROW_LANES),
      .BANK_IDX((g % ROW_LANES) / BANK_LANES)
    ) u_lane (
      .picked   (picked),
      .old_word (old_vec[g*DW +: DW]),
      .src_ok   (ok),
      .hold     (bad),
      .zero_fill(zero_fill),
      .row_mask (row_mask),
      .bank_mask(bank_mask),
      .out_word (nxt_vec[g*DW +: DW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vec <= '0;
      illegal <= 1'b0;
      live    <= 1'b0;
    end else begin
      res_vec <= nxt_vec;
      illegal <= bad;
      live    <= 1'b1;
    end
  end

  // Output reflects the previous cycle's inputs only once live is set.
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (res_vec == '0) && !illegal);

  assert_row_off_R7: assert property (@(posedge clk) disable iff (rst)
    live && ($past(row_mask) == '0) |-> (res_vec == $past(old_vec)));

  assert_illegal_hold_R9: assert property (@(posedge clk) disable iff (rst)
    live && illegal |-> (res_vec == $past(old_vec)));

  assert_row_reverse_R5: assert property (@(posedge clk) disable iff (rst)
    live && ($past(kind) == LP_ROW_REV) && ($past(row_mask) == {ROWS{1'b1}}) &&
    ($past(bank_mask) == {BANKS{1'b1}})
    |-> (res_vec[DW-1:0] == $past(src_vec[ROW_LANES*DW-1 -: DW])));

  assert_wave_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    live && ($past(kind) == LP_WAVE_SPIN_L) && ($past(row_mask) == {ROWS{1'b1}}) &&
    ($past(bank_mask) == {BANKS{1'b1}})
    |-> (res_vec[VW-1 -: DW] == $past(src_vec[DW-1:0])));

  assert_zero_fill_R8: assert property (@(posedge clk) disable iff (rst)
    live && ($past(kind) == LP_WAVE_PULL_LO) && $past(row_mask[0]) &&
    $past(bank_mask[0]) && $past(zero_fill)
    |-> (res_vec[DW-1:0] == '0));

endmodule

// File: tb/lperm_net_bench.sv
`timescale 1ns/1ps
module lperm_net_bench;

  localparam int LANES = 64;
  localparam int DW    = 32;
  localparam int VW    = LANES * DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [VW-1:0] src_vec = '0;
  logic [VW-1:0] old_vec = '0;
  logic [3:0]    kind = '0;
  logic [7:0]    perm_arg = '0;
  logic [3:0]    row_mask = 4'hF;
  logic [3:0]    bank_mask = 4'hF;
  logic          zero_fill = 1'b0;
  logic [VW-1:0] res_vec;
  logic          illegal;

  int checks = 0;
  int failures = 0;
  int seed = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lperm_net u_lperm_net (
    .clk(clk), .rst(rst), .src_vec(src_vec), .old_vec(old_vec),
    .kind(kind), .perm_arg(perm_arg), .row_mask(row_mask),
    .bank_mask(bank_mask), .zero_fill(zero_fill),
    .res_vec(res_vec), .illegal(illegal)
  );

  function automatic void model(input int k, input int a, input logic [3:0] rm,
                                input logic [3:0] bm, input logic bz,
                                output logic [VW-1:0] ev, output logic eill);
    bit bad;
    bad = (k > 11) || ((k >= 1) && (k <= 3) && ((a < 1) || (a > 15)));
    eill = bad;
    for (int l = 0; l < LANES; l++) begin
      int row, p, s;
      row = l / 16;
      p   = l % 16;
      s   = -1;
      case (k)
        0:  s = (l / 4) * 4 + ((a >> (2 * (l % 4))) & 3);
        1:  if (p + a < 16) s = l + a;
        2:  if (p >= a) s = l - a;
        3:  s = row * 16 + ((p + 16 - (a % 16)) % 16);
        4:  if (l < 63) s = l + 1;
        5:  if (l > 0) s = l - 1;
        6:  s = (l + 63) % 64;
        7:  s = (l + 1) % 64;
        8:  s = row * 16 + 15 - p;
        9:  s = row * 16 + (p / 8) * 8 + 7 - (p % 8);
        10: if (row > 0) s = row * 16 - 1;
        11: if (row >= 2) s = 31;
        default: s = -1;
      endcase
      if (bad || !rm[row] || !bm[p / 4])
        ev[l*DW +: DW] = old_vec[l*DW +: DW];
      else if (s < 0)
        ev[l*DW +: DW] = bz ? '0 : old_vec[l*DW +: DW];
      else
        ev[l*DW +: DW] = src_vec[s*DW +: DW];
    end
  endfunction

  task automatic run_case(input string req, input int k, input int a,
                          input logic [3:0] rm, input logic [3:0] bm,
                          input logic bz);
    logic [VW-1:0] ev;
    logic eill;
    int bad_lane;
    seed++;
    for (int l = 0; l < LANES; l++) begin
      src_vec[l*DW +: DW] = 32'hC0DE0000 + l * 32'h101 + seed;
      old_vec[l*DW +: DW] = 32'h0BAD0000 + l + (seed << 8);
    end
    kind = 4'(k); perm_arg = 8'(a); row_mask = rm; bank_mask = bm; zero_fill = bz;
    model(k, a, rm, bm, bz, ev, eill);
    @(negedge clk);
    checks++;
    bad_lane = -1;
    for (int l = LANES - 1; l >= 0; l--)
      if (res_vec[l*DW +: DW] !== ev[l*DW +: DW]) bad_lane = l;
    if (bad_lane >= 0) begin
      failures++;
      $display("FAIL %s kind=%0d arg=%0d lane %0d: actual=%h expected=%h", req, k, a,
               bad_lane, res_vec[bad_lane*DW +: DW], ev[bad_lane*DW +: DW]);
    end
    checks++;
    if (illegal !== eill) begin
      failures++;
      $display("FAIL %s kind=%0d arg=%0d illegal: actual=%b expected=%b", req, k, a,
               illegal, eill);
    end
  endtask

  task automatic t_reset;  // R10
    checks++;
    if (res_vec !== '0 || illegal !== 1'b0) begin
      failures++;
      $display("FAIL R10 reset: actual=%h/%b expected=0/0", res_vec[DW-1:0], illegal);
    end
  endtask

  task automatic t_quad;  // R1
    run_case("R1", 0, 8'h1B, 4'hF, 4'hF, 1'b0);
    run_case("R1", 0, 8'h00, 4'hF, 4'hF, 1'b1);
    run_case("R1", 0, 8'hE4, 4'hF, 4'hF, 1'b0);
  endtask

  task automatic t_row_move;  // R2 and R8
    run_case("R2", 1, 1, 4'hF, 4'hF, 1'b1);
    run_case("R2", 1, 15, 4'hF, 4'hF, 1'b0);
    run_case("R2", 2, 4, 4'hF, 4'hF, 1'b1);
    run_case("R8", 2, 3, 4'hF, 4'hF, 1'b0);
  endtask

  task automatic t_row_spin;  // R3
    run_case("R3", 3, 1, 4'hF, 4'hF, 1'b0);
    run_case("R3", 3, 9, 4'hF, 4'hF, 1'b1);
  endtask

  task automatic t_wave;  // R4
    run_case("R4", 4, 0, 4'hF, 4'hF, 1'b1);
    run_case("R4", 5, 0, 4'hF, 4'hF, 1'b1);
    run_case("R4", 5, 0, 4'hF, 4'hF, 1'b0);
    run_case("R4", 6, 0, 4'hF, 4'hF, 1'b0);
    run_case("R4", 7, 0, 4'hF, 4'hF, 1'b0);
  endtask

  task automatic t_reverse;  // R5
    run_case("R5", 8, 0, 4'hF, 4'hF, 1'b0);
    run_case("R5", 9, 0, 4'hF, 4'hF, 1'b0);
  endtask

  task automatic t_bcast;  // R6
    run_case("R6", 10, 0, 4'hF, 4'hF, 1'b1);
    run_case("R6", 11, 0, 4'hF, 4'hF, 1'b0);
    run_case("R6", 11, 0, 4'hF, 4'hF, 1'b1);
  endtask

  task automatic t_masks;  // R7
    run_case("R7", 8, 0, 4'b0101, 4'b1010, 1'b0);
    run_case("R7", 5, 0, 4'hF, 4'b1110, 1'b1);
    run_case("R7", 10, 0, 4'b0000, 4'hF, 1'b1);
    run_case("R7", 11, 0, 4'b1001, 4'b0110, 1'b1);
  endtask

  task automatic t_illegal;  // R9
    run_case("R9", 1, 0, 4'hF, 4'hF, 1'b1);
    run_case("R9", 3, 16, 4'hF, 4'hF, 1'b0);
    run_case("R9", 12, 0, 4'hF, 4'hF, 1'b1);
    run_case("R9", 15, 0, 4'hF, 4'hF, 1'b0);
    run_case("R9", 2, 15, 4'hF, 4'hF, 1'b1);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_quad();
    t_row_move();
    t_row_spin();
    t_wave();
    t_reverse();
    t_bcast();
    t_masks();
    t_illegal();
    done = 1'b1;
    finish_run();
  end

endmodule